// File: doc/BRIEF.md
# Sixteen-Bit Timer with Two Compare Channels

This block is an up-counting 16-bit timer with two output compare channels, A and B. A CPU reaches it over an 8-bit register bus. Each channel holds a 16-bit compare value and checks it against the counter on every timer tick. A genuine match sets the channel's flag and moves its waveform pin as its 2-bit output mode selects. In normal mode the counter wraps from all ones to zero and raises an overflow flag. In clear-on-compare mode, channel A's compare value is the top of the count.

Sixteen-bit values cross the 8-bit bus through one temporary byte that all 16-bit registers share. On a write, the high byte goes first and only lands in the temporary byte. The low-byte write then commits both halves together. On a read, the low byte goes first; that read copies the high half into the temporary byte, and the following high-byte read returns it. A write to the counter mutes compare matching for the next timer tick. Force strobes move a waveform pin without touching the flags or the counter.

Two small state machines carry the timing. The counter sequencer has two states. In SEQ_LIVE, matches count. A counter write moves it to SEQ_MUTED, where it stays through further counter writes. The first timer tick without a counter write returns it to SEQ_LIVE. Each channel's pin is a two-state machine with states PIN_LOW and PIN_HIGH. A match or force event moves it from PIN_LOW to PIN_HIGH under the toggle or set modes, and from PIN_HIGH to PIN_LOW under the toggle or clear modes. Otherwise it stays where it is.

Top module: `tmr16_dual`

## Requirements
- R1: After reset the counter, both compare values, the control byte, all flags and both pins are zero.
- R2: A write to a high-byte address (counter 0x29, compare A 0x27, compare B 0x25) only loads the temporary byte. A write to the matching low-byte address (0x28, 0x26, 0x24) loads {temporary byte, written byte} into the 16-bit register in one cycle.
- R3: A read of a low-byte address returns the low half and copies that register's high half into the temporary byte. A read of any high-byte address returns the temporary byte, which is shared by all three registers.
- R4: On each cycle with the tick input high, the counter advances by one. A CPU counter write in the same cycle takes priority: the written value is loaded and that tick is dropped.
- R5: After a counter write, the next timer tick produces no compare match on either channel, though the counter still advances on it. Matching resumes on the tick after that.
- R6: A match on a tick sets the channel flag. The flag register at 0x2B holds the overflow flag in bit 0, channel A in bit 1 and channel B in bit 2. Writing a one to a bit clears that flag; writing a zero leaves it unchanged.
- R7: The control byte at 0x2E holds channel A's mode in bits 7:6, channel B's mode in bits 5:4 and clear-on-compare in bit 0; bits 3:1 read as zero. Mode 00 leaves the pin untouched, 01 toggles it, 10 drives it low and 11 drives it high on a match.
- R8: In clear-on-compare mode, a match on channel A returns the counter to zero on that tick instead of advancing it.
- R9: A one written to bit 7 (channel A) or bit 6 (channel B) of the force byte at 0x2D moves that pin as its mode selects. It sets no flag and never clears the counter, and the force byte always reads as zero.
- R10: In normal mode a tick at 0xFFFF wraps the counter to zero and sets the overflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Timer-clock enable, one count per high cycle |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 6 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the read cycle |
| wave_a | output | 1 | Channel A waveform pin |
| wave_b | output | 1 | Channel B waveform pin |
| irq_ovf | output | 1 | Overflow flag |
| irq_a | output | 1 | Channel A match flag |
| irq_b | output | 1 | Channel B match flag |

## Verification
The hardest case to reach from the ports is a muted tick that lands exactly on a compare value. The stimulus writes the counter equal to the compare value and then gives one tick. It checks that neither the flag nor the pin moved while the counter still advanced. It then writes a value one below the compare value and gives two ticks, to show that matching resumes. A tick in the same cycle as a counter write is driven by holding the tick input high across the low-byte write. The force cases are run with the counter parked on the top value in clear-on-compare mode, so that any unwanted clear would show up in the counter read-back.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int REG_W  = 8;
    localparam int AW     = 6;
    localparam int NUM_CH = 2;

    typedef enum logic [1:0] {
        OUT_OFF    = 2'b00,
        OUT_TOGGLE = 2'b01,
        OUT_LOW    = 2'b10,
        OUT_HIGH   = 2'b11
    } out_mode_e;

    typedef enum logic {
        SEQ_LIVE  = 1'b0,
        SEQ_MUTED = 1'b1
    } seq_state_e;

    typedef enum logic {
        PIN_LOW  = 1'b0,
        PIN_HIGH = 1'b1
    } pin_state_e;

    localparam logic [AW-1:0] ADR_CNT_HI  = 6'h29;
    localparam logic [AW-1:0] ADR_CNT_LO  = 6'h28;
    localparam logic [AW-1:0] ADR_CMPA_HI = 6'h27;
    localparam logic [AW-1:0] ADR_FLAGS   = 6'h2B;
    localparam logic [AW-1:0] ADR_FORCE   = 6'h2D;
    localparam logic [AW-1:0] ADR_CTRL    = 6'h2E;

endpackage

// File: rtl/tmr_regif.sv
module tmr_regif
    import tmr_pkg::*;
#(
    parameter int DW   = REG_W,
    parameter int AWP  = AW,
    parameter int NCH  = NUM_CH,
    localparam int CW  = 2 * DW
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic                     rd_en,
    input  logic [AWP-1:0]           addr,
    input  logic [DW-1:0]            wdata,
    output logic [DW-1:0]            rdata,
    input  logic [CW-1:0]            cnt,
    input  logic [NCH:0]             flags,
    output logic                     cnt_wr,
    output logic [CW-1:0]            cnt_wdata,
    output logic [NCH-1:0][CW-1:0]   cmp_val,
    output logic [NCH-1:0][1:0]      mode_bits,
    output logic                     ctc,
    output logic [NCH-1:0]           force_stb,
    output logic [NCH:0]             flag_clr
);

    logic [DW-1:0]          temp_q;
    logic [NCH-1:0][CW-1:0] cmp_q;
    logic [NCH-1:0][1:0]    mode_q;
    logic                   ctc_q;
    logic                   hit_hi;
    logic                   hit_lo;
    logic [CW-1:0]          sel_word;
    logic [DW-1:0]          ctrl_byte;

    // address decode for the 16-bit pairs and the word behind a low byte
    always_comb begin
        hit_hi   = 1'b0;
        hit_lo   = 1'b0;
        sel_word = '0;
        if (addr == ADR_CNT_HI) hit_hi = 1'b1;
        if (addr == ADR_CNT_LO) begin
            hit_lo   = 1'b1;
            sel_word = cnt;
        end
        for (int i = 0; i < NCH; i++) begin
            if (addr == ADR_CMPA_HI - AWP'(2 * i)) hit_hi = 1'b1;
            if (addr == ADR_CMPA_HI - AWP'(2 * i + 1)) begin
                hit_lo   = 1'b1;
                sel_word = cmp_q[i];
            end
        end
    end

    // shared temporary byte
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            temp_q <= '0;
        end else if (wr_en && hit_hi) begin
            temp_q <= wdata;
        end else if (rd_en && hit_lo && !wr_en) begin
            temp_q <= sel_word[CW-1:DW];
        end
    end

    // control byte
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            ctc_q  <= 1'b0;
        end else if (wr_en && addr == ADR_CTRL) begin
            for (int i = 0; i < NCH; i++) begin
                mode_q[i] <= wdata[DW-1-2*i -: 2];
            end
            ctc_q <= wdata[0];
        end
    end

    always_comb begin
        ctrl_byte = '0;
        for (int i = 0; i < NCH; i++) begin
            ctrl_byte[DW-1-2*i -: 2] = mode_q[i];
        end
        ctrl_byte[0] = ctc_q;
    end

    // compare registers, force strobes and per-channel flag clears
    for (genvar g = 0; g < NCH; g++) begin : g_cmp
        localparam logic [AWP-1:0] LO_ADR = ADR_CMPA_HI - AWP'(2 * g + 1);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cmp_q[g] <= '0;
            end else if (wr_en && addr == LO_ADR) begin
                cmp_q[g] <= {temp_q, wdata};
            end
        end

        assign force_stb[g]  = wr_en && (addr == ADR_FORCE) && wdata[DW-1-g];
        assign flag_clr[g+1] = wr_en && (addr == ADR_FLAGS) && wdata[g+1];
    end

    assign flag_clr[0] = wr_en && (addr == ADR_FLAGS) && wdata[0];
    assign cnt_wr      = wr_en && (addr == ADR_CNT_LO);
    assign cnt_wdata   = {temp_q, wdata};
    assign cmp_val     = cmp_q;
    assign mode_bits   = mode_q;
    assign ctc         = ctc_q;

    // read mux; the force byte and unknown addresses read as zero
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (hit_lo) begin
                rdata = sel_word[DW-1:0];
            end else if (hit_hi) begin
                rdata = temp_q;
            end else if (addr == ADR_FLAGS) begin
                rdata = DW'(flags);
            end else if (addr == ADR_CTRL) begin
                rdata = ctrl_byte;
            end
        end
    end

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int CW = 2 * REG_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          cnt_wr,
    input  logic [CW-1:0] cnt_wdata,
    input  logic          ctc,
    input  logic          top_match,
    input  logic          ovf_clr,
    output logic [CW-1:0] cnt,
    output logic          live,
    output logic          ovf_flag
);

    localparam logic [CW-1:0] CNT_MAX = '1;

    seq_state_e state_q;
    seq_state_e state_d;
    logic [CW-1:0] cnt_q;
    logic          ovf_q;
    logic          wrap_evt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEQ_LIVE;
        else        state_q <= state_d;
    end

    // transitions: a counter write mutes, the next tick without a write unmutes
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_LIVE:  if (cnt_wr) state_d = SEQ_MUTED;
            SEQ_MUTED: begin
                if (cnt_wr)    state_d = SEQ_MUTED;
                else if (tick) state_d = SEQ_LIVE;
            end
        endcase
    end

    // outputs of the sequencer
    always_comb begin
        live = 1'b0;
        unique case (state_q)
            SEQ_LIVE:  live = !cnt_wr;
            SEQ_MUTED: live = 1'b0;
        endcase
    end

    assign wrap_evt = tick && !cnt_wr && !ctc && (cnt_q == CNT_MAX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_wr) begin
            cnt_q <= cnt_wdata;
        end else if (tick) begin
            if (ctc && top_match) cnt_q <= '0;
            else                  cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        ovf_q <= 1'b0;
        else if (wrap_evt) ovf_q <= 1'b1;
        else if (ovf_clr)  ovf_q <= 1'b0;
    end

    assign cnt      = cnt_q;
    assign ovf_flag = ovf_q;

endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_pkg::*;
#(
    parameter int CW = 2 * REG_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          live,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] cmp,
    input  logic [1:0]    mode,
    input  logic          force_stb,
    input  logic          flag_clr,
    output logic          match,
    output logic          flag,
    output logic          pin
);

    pin_state_e pin_q;
    pin_state_e pin_d;
    out_mode_e  mode_e;
    logic       act;
    logic       flag_q;

    assign mode_e = out_mode_e'(mode);
    assign match  = tick && live && (cnt == cmp);
    assign act    = match || force_stb;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_q <= PIN_LOW;
        else        pin_q <= pin_d;
    end

    always_comb begin
        pin_d = pin_q;
        unique case (pin_q)
            PIN_LOW:  if (act && (mode_e == OUT_TOGGLE || mode_e == OUT_HIGH)) pin_d = PIN_HIGH;
            PIN_HIGH: if (act && (mode_e == OUT_TOGGLE || mode_e == OUT_LOW))  pin_d = PIN_LOW;
        endcase
    end

    always_comb begin
        pin = 1'b0;
        unique case (pin_q)
            PIN_LOW:  pin = 1'b0;
            PIN_HIGH: pin = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (match)    flag_q <= 1'b1;
        else if (flag_clr) flag_q <= 1'b0;
    end

    assign flag = flag_q;

endmodule

// File: rtl/tmr16_dual.sv
module tmr16_dual
    import tmr_pkg::*;
#(
    parameter int DW  = REG_W,
    parameter int AWP = AW,
    localparam int NCH = NUM_CH,
    localparam int CW  = 2 * DW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic           bus_wr,
    input  logic           bus_rd,
    input  logic [AWP-1:0] bus_addr,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    output logic           wave_a,
    output logic           wave_b,
    output logic           irq_ovf,
    output logic           irq_a,
    output logic           irq_b
);

    logic [CW-1:0]          cnt_q;
    logic                   cnt_wr;
    logic [CW-1:0]          cnt_wdata;
    logic [NCH-1:0][CW-1:0] cmp_val;
    logic [NCH-1:0][1:0]    mode_bits;
    logic                   ctc_q;
    logic [NCH-1:0]         force_stb;
    logic [NCH:0]           flag_clr;
    logic [NCH:0]           flag_vec;
    logic [NCH-1:0]         match_vec;
    logic [NCH-1:0]         wave_vec;
    logic                   live;

    tmr_regif #(.DW(DW), .AWP(AWP), .NCH(NCH)) u_regif (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_wr),
        .rd_en     (bus_rd),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .rdata     (bus_rdata),
        .cnt       (cnt_q),
        .flags     (flag_vec),
        .cnt_wr    (cnt_wr),
        .cnt_wdata (cnt_wdata),
        .cmp_val   (cmp_val),
        .mode_bits (mode_bits),
        .ctc       (ctc_q),
        .force_stb (force_stb),
        .flag_clr  (flag_clr)
    );

    tmr_counter #(.CW(CW)) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .cnt_wr    (cnt_wr),
        .cnt_wdata (cnt_wdata),
        .ctc       (ctc_q),
        .top_match (match_vec[0]),
        .ovf_clr   (flag_clr[0]),
        .cnt       (cnt_q),
        .live      (live),
        .ovf_flag  (flag_vec[0])
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        tmr_chan #(.CW(CW)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (tick),
            .live      (live),
            .cnt       (cnt_q),
            .cmp       (cmp_val[g]),
            .mode      (mode_bits[g]),
            .force_stb (force_stb[g]),
            .flag_clr  (flag_clr[g+1]),
            .match     (match_vec[g]),
            .flag      (flag_vec[g+1]),
            .pin       (wave_vec[g])
        );
    end

    assign wave_a  = wave_vec[0];
    assign wave_b  = wave_vec[1];
    assign irq_ovf = flag_vec[0];
    assign irq_a   = flag_vec[1];
    assign irq_b   = flag_vec[2];

endmodule

// File: rtl/tmr16_dual_chk.sv
module tmr16_dual_chk
    import tmr_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          tick,
    input logic          bus_wr,
    input logic          bus_rd,
    input logic [5:0]    bus_addr,
    input logic [7:0]    bus_wdata,
    input logic [7:0]    bus_rdata,
    input logic [15:0]   cnt,
    input logic          ctc,
    input logic          live,
    input logic [1:0]    match,
    input logic          irq_ovf,
    input logic          irq_a
);

    logic cw;
    assign cw = bus_wr && (bus_addr == ADR_CNT_LO);

    AST_STEP_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cw && !(ctc && match[0])) |=> (cnt == 16'($past(cnt) + 16'd1))); // R4

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cw) |=> $stable(cnt)); // R4

    AST_MUTE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        cw |=> (match == 2'b00)); // R5

    AST_CTC_TOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (ctc && match[0]) |=> (cnt == 16'h0000)); // R8

    AST_FORCE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADR_FORCE && bus_wdata[7] && !match[0] && !irq_a) |=> !irq_a); // R9

    AST_FORCE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && bus_addr == ADR_FORCE) |-> (bus_rdata == 8'h00)); // R9

    AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && live && !ctc && cnt == 16'hFFFF) |=> (irq_ovf && cnt == 16'h0000)); // R10

endmodule

bind tmr16_dual tmr16_dual_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cnt       (cnt_q),
    .ctc       (ctc_q),
    .live      (live),
    .match     (match_vec),
    .irq_ovf   (irq_ovf),
    .irq_a     (irq_a)
);

// File: tb/tmr16_dual_tb_top.sv
`timescale 1ns/100ps
module tmr16_dual_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [5:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       wave_a, wave_b, irq_ovf, irq_a, irq_b;

    typedef struct {
        int          sel;
        logic [7:0]  exp;
        string       tag;
    } item_t;

    item_t exp_q[$];
    logic  chk_valid = 1'b0;
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;

    always #2.5 clk = ~clk;

    tmr16_dual dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .wave_a    (wave_a),
        .wave_b    (wave_b),
        .irq_ovf   (irq_ovf),
        .irq_a     (irq_a),
        .irq_b     (irq_b)
    );

    // monitor: pops one expected item per flagged cycle, away from the edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (chk_valid) begin
                logic [7:0] act;
                item_t it;
                it = exp_q.pop_front();
                case (it.sel)
                    0:       act = bus_rdata;
                    1:       act = {6'b0, wave_b, wave_a};
                    default: act = {5'b0, irq_b, irq_a, irq_ovf};
                endcase
                n_cmp++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: actual 0x%02h expected 0x%02h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic wr16(input logic [5:0] hi, input logic [15:0] v);
        wr(hi, v[15:8]);
        wr(hi - 6'd1, v[7:0]);
    endtask

    task automatic rd(input logic [5:0] a, input logic [7:0] e, input string tag);
        item_t it;
        it.sel = 0; it.exp = e; it.tag = tag;
        exp_q.push_back(it);
        bus_rd = 1'b1; bus_addr = a; chk_valid = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0; chk_valid = 1'b0;
    endtask

    task automatic look(input int sel, input logic [7:0] e, input string tag);
        item_t it;
        it.sel = sel; it.exp = e; it.tag = tag;
        exp_q.push_back(it);
        chk_valid = 1'b1;
        @(negedge clk);
        chk_valid = 1'b0;
    endtask

    task automatic ticks(input int n);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(6'h28, 8'h00, "R1 counter low");
        rd(6'h29, 8'h00, "R1 counter high");
        rd(6'h26, 8'h00, "R1 compare A low");
        rd(6'h24, 8'h00, "R1 compare B low");
        rd(6'h2E, 8'h00, "R1 control");
        look(1, 8'h00, "R1 pins");
        look(2, 8'h00, "R1 flags");

        // R2 high write only loads temp; low write commits
        wr(6'h29, 8'h12);
        rd(6'h28, 8'h00, "R2 high write alone");
        wr16(6'h29, 16'h1234);
        rd(6'h28, 8'h34, "R2 counter low after commit");
        rd(6'h29, 8'h12, "R3 high read returns temp");

        // R3 temp shared across registers
        rd(6'h28, 8'h34, "R3 low read");
        rd(6'h27, 8'h12, "R3 shared temp on compare A high");

        // R4 counting, muted first tick still counts
        ticks(5);
        rd(6'h28, 8'h39, "R4 five ticks");
        wr(6'h29, 8'h01);
        tick = 1'b1;
        wr(6'h28, 8'h00);
        tick = 1'b0;
        rd(6'h28, 8'h00, "R4 write beats tick low");
        rd(6'h29, 8'h01, "R4 write beats tick high");

        // R6 R7 match with toggle on A and disconnected B
        wr(6'h2E, 8'h40);
        wr16(6'h27, 16'h0010);
        wr16(6'h25, 16'h0010);
        wr16(6'h29, 16'h000E);
        ticks(2);
        look(1, 8'h00, "R7 pins before match");
        look(2, 8'h00, "R6 flags before match");
        ticks(1);
        look(1, 8'h01, "R7 toggle on A, B disconnected");
        look(2, 8'h06, "R6 flags after match");
        rd(6'h2B, 8'h06, "R6 flag register");
        wr(6'h2B, 8'h02);
        rd(6'h2B, 8'h04, "R6 clear A only");
        wr(6'h2B, 8'h04);
        rd(6'h2B, 8'h00, "R6 clear B");

        // R5 muted tick after counter write
        wr16(6'h29, 16'h0010);
        ticks(1);
        look(2, 8'h00, "R5 no flag on muted tick");
        look(1, 8'h01, "R5 pin unchanged on muted tick");
        rd(6'h28, 8'h11, "R5 counter advanced on muted tick");
        wr16(6'h29, 16'h000F);
        ticks(2);
        look(2, 8'h06, "R5 matching resumes");
        look(1, 8'h00, "R5 toggle after resume");
        wr(6'h2B, 8'h07);

        // R8 clear-on-compare with set mode on A
        wr(6'h2E, 8'hC1);
        wr16(6'h29, 16'h000E);
        ticks(3);
        rd(6'h28, 8'h00, "R8 counter cleared low");
        rd(6'h29, 8'h00, "R8 counter cleared high");
        look(1, 8'h01, "R7 set mode on A");
        look(2, 8'h06, "R8 flags on top match");
        ticks(1);
        rd(6'h28, 8'h01, "R8 counts from zero");
        wr(6'h2B, 8'h07);

        // R7 reserved control bits; R9 force
        wr(6'h2E, 8'hFF);
        rd(6'h2E, 8'hF1, "R7 reserved bits read zero");
        wr(6'h2E, 8'hB1);
        wr16(6'h29, 16'h0010);
        wr(6'h2D, 8'hC0);
        look(1, 8'h02, "R9 force clear A, set B");
        look(2, 8'h00, "R9 force sets no flag");
        rd(6'h28, 8'h10, "R9 force leaves counter at top");
        rd(6'h2D, 8'h00, "R9 force byte reads zero");
        wr(6'h2E, 8'h51);
        wr(6'h2D, 8'h80);
        look(1, 8'h03, "R9 force toggle A only");
        look(2, 8'h00, "R9 no flag after toggle force");

        // R10 overflow in normal mode
        wr(6'h2E, 8'h00);
        wr16(6'h29, 16'hFFFE);
        ticks(2);
        look(2, 8'h01, "R10 overflow flag");
        rd(6'h28, 8'h00, "R10 wrap low");
        rd(6'h29, 8'h00, "R10 wrap high");
        wr(6'h2B, 8'h01);
        look(2, 8'h00, "R6 overflow cleared by one");

        repeat (2) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard: actual %0d left expected 0", exp_q.size());
        end
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule